// File: doc/BRIEF.md
# GPIO Interrupt Cause Aggregator

This block turns a bank of polarity-corrected GPIO input lines into a few interrupt requests for a main interrupt controller. Each line can raise a level interrupt or an edge interrupt. A level interrupt follows the corrected input directly and is gated by a level-mask bit. An edge interrupt comes from a cause bit that is latched when the corrected input rises and is gated by an edge-mask bit. Level-sensitive lines are high-active and edge lines detect rising transitions. To get low-active or falling behaviour, software inverts the line in the upstream polarity stage.

For each line, the level and edge causes are ORed together. These per-line causes are then ORed across each group of consecutive lines, eight by default, and each group result drives one registered summary output. Software reads and writes the edge-cause, edge-mask and level-mask registers through a simple single-cycle register port. A write to the cause register clears only the bits written as zero. The two mask registers can be moved by a configurable extra address offset.

Top module: `gpio_irq_agg`

## Requirements
- R1: After reset, the edge-cause, edge-mask and level-mask registers all read 0 and every summary output is 0.
- R2: The edge-cause bit of a line is set when that line's input is 0 on one clock edge and 1 on the next, counted from the second clock after reset. It stays set until software clears it. A falling transition sets nothing.
- R3: The level mask is at address 0x1C plus MASK_OFS and is read/write. A line's level cause is its input AND its level-mask bit.
- R4: The edge mask is at address 0x18 plus MASK_OFS and is read/write. A line's edge cause is its edge-cause bit AND its edge-mask bit.
- R5: The edge cause is at address 0x14. A write clears exactly the bits written as 0 and leaves the bits written as 1 unchanged.
- R6: Summary output g is the OR of the level and edge causes of lines g*GROUP_W to g*GROUP_W+GROUP_W-1. Other groups have no effect on it.
- R7: Summary outputs are registered. They reflect the per-line causes of the previous clock edge, so they change one cycle after a cause or mask changes.
- R8: If a rising edge and a clearing write hit the same cause bit in the same cycle, the bit ends up at 1.
- R9: Reads return the addressed register on reg_rdata in the same cycle. An address that matches no register reads 0. This includes 0x18 and 0x1C when MASK_OFS is nonzero.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| din | input | NUM_LINES | Polarity-corrected, synchronized input lines |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | ADDR_W | Register byte address |
| reg_wdata | input | NUM_LINES | Register write data |
| reg_rdata | output | NUM_LINES | Register read data (combinational) |
| irq_grp | output | NUM_LINES/GROUP_W | Registered per-group summary interrupts |

## Verification
A level interrupt shows on its summary output one edge after the input changes. An edge interrupt takes two edges: one to latch the cause and one to register the summary. A mask write is visible on read-back right after its edge and reaches the summary output one edge later. The bench drives inputs at the falling edge and samples half a cycle after each rising edge. Where the requirements predict no change yet, it also checks that the output is still at its old value.

// File: rtl/gpio_irq_pkg.sv
package gpio_irq_pkg;
   localparam int CAUSE_OFS = 32'h14;
   localparam int EMASK_OFS = 32'h18;
   localparam int LMASK_OFS = 32'h1C;

   function automatic int grp_count(input int lines, input int gw);
      return lines / gw;
   endfunction
endpackage

// File: rtl/gpio_irq_edge.sv
module gpio_irq_edge #(
   parameter int N = 32
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic [N-1:0] din,
   input  logic         clr_en,
   input  logic [N-1:0] clr_keep,
   output logic [N-1:0] cause_q,
   output logic [N-1:0] set_o
);
   logic [N-1:0] prev_q;
   logic         primed_q;
   logic [N-1:0] keep;

   assign set_o = din & ~prev_q & {N{primed_q}};
   assign keep  = clr_en ? clr_keep : {N{1'b1}};

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         prev_q   <= '0;
         primed_q <= 1'b0;
         cause_q  <= '0;
      end else begin
         prev_q   <= din;
         primed_q <= 1'b1;
         cause_q  <= (cause_q & keep) | set_o;
      end
   end
endmodule

// File: rtl/gpio_irq_regs.sv
module gpio_irq_regs
   import gpio_irq_pkg::*;
#(
   parameter int N        = 32,
   parameter int ADDR_W   = 8,
   parameter int MASK_OFS = 0
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              wr,
   input  logic [ADDR_W-1:0] addr,
   input  logic [N-1:0]      wdata,
   input  logic [N-1:0]      cause_q,
   output logic              cause_wr,
   output logic [N-1:0]      emask_q,
   output logic [N-1:0]      lmask_q,
   output logic [N-1:0]      rdata
);
   localparam logic [ADDR_W-1:0] A_CAUSE = ADDR_W'(CAUSE_OFS);
   localparam logic [ADDR_W-1:0] A_EMASK = ADDR_W'(EMASK_OFS + MASK_OFS);
   localparam logic [ADDR_W-1:0] A_LMASK = ADDR_W'(LMASK_OFS + MASK_OFS);

   logic hit_c, hit_e, hit_l;

   assign hit_c    = (addr == A_CAUSE);
   assign hit_e    = (addr == A_EMASK);
   assign hit_l    = (addr == A_LMASK);
   assign cause_wr = wr & hit_c;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         emask_q <= '0;
         lmask_q <= '0;
      end else if (wr) begin
         if (hit_e) emask_q <= wdata;
         if (hit_l) lmask_q <= wdata;
      end
   end

   always_comb begin
      rdata = '0;
      if (hit_c)      rdata = cause_q;
      else if (hit_e) rdata = emask_q;
      else if (hit_l) rdata = lmask_q;
   end
endmodule

// File: rtl/gpio_irq_group.sv
module gpio_irq_group #(
   parameter int N       = 32,
   parameter int GW      = 8,
   parameter bit REG_OUT = 1'b1
) (
   input  logic           clk,
   input  logic           rst_n,
   input  logic [N-1:0]   line_cause,
   output logic [N/GW-1:0] irq
);
   localparam int NG = N / GW;

   logic [NG-1:0] any;

   for (genvar g = 0; g < NG; g++) begin : g_or
      assign any[g] = |line_cause[g*GW +: GW];
   end

   if (REG_OUT) begin : g_reg
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) irq <= '0;
         else        irq <= any;
      end
   end else begin : g_comb
      assign irq = any;
   end
endmodule

// File: rtl/gpio_irq_agg.sv
module gpio_irq_agg
   import gpio_irq_pkg::*;
#(
   parameter int NUM_LINES = 32,
   parameter int GROUP_W   = 8,
   parameter int ADDR_W    = 8,
   parameter int MASK_OFS  = 0,
   parameter bit SUM_REG   = 1'b1
) (
   input  logic                         clk,
   input  logic                         rst_n,
   input  logic [NUM_LINES-1:0]         din,
   input  logic                         reg_wr,
   input  logic [ADDR_W-1:0]            reg_addr,
   input  logic [NUM_LINES-1:0]         reg_wdata,
   output logic [NUM_LINES-1:0]         reg_rdata,
   output logic [NUM_LINES/GROUP_W-1:0] irq_grp
);
   localparam int NUM_GRP = grp_count(NUM_LINES, GROUP_W);

   if (NUM_LINES % GROUP_W != 0) begin : g_chk_div
      $error("NUM_LINES must be a multiple of GROUP_W");
   end
   if (NUM_GRP < 1) begin : g_chk_grp
      $error("at least one group required");
   end
   if ((1 << ADDR_W) <= LMASK_OFS + MASK_OFS) begin : g_chk_addr
      $error("ADDR_W too narrow for register map");
   end

   logic [NUM_LINES-1:0] cause_q, emask_q, lmask_q, edge_set, line_cause;
   logic                 cause_wr;

   gpio_irq_regs #(.N(NUM_LINES), .ADDR_W(ADDR_W), .MASK_OFS(MASK_OFS)) u_regs (
      .clk(clk), .rst_n(rst_n), .wr(reg_wr), .addr(reg_addr), .wdata(reg_wdata),
      .cause_q(cause_q), .cause_wr(cause_wr), .emask_q(emask_q),
      .lmask_q(lmask_q), .rdata(reg_rdata)
   );

   gpio_irq_edge #(.N(NUM_LINES)) u_edge (
      .clk(clk), .rst_n(rst_n), .din(din), .clr_en(cause_wr),
      .clr_keep(reg_wdata), .cause_q(cause_q), .set_o(edge_set)
   );

   assign line_cause = (din & lmask_q) | (cause_q & emask_q);

   gpio_irq_group #(.N(NUM_LINES), .GW(GROUP_W), .REG_OUT(SUM_REG)) u_grp (
      .clk(clk), .rst_n(rst_n), .line_cause(line_cause), .irq(irq_grp)
   );
endmodule

// File: rtl/gpio_irq_chk.sv
module gpio_irq_chk
   import gpio_irq_pkg::*;
#(
   parameter int N        = 32,
   parameter int GW       = 8,
   parameter int ADDR_W   = 8,
   parameter int MASK_OFS = 0,
   parameter bit SUM_REG  = 1'b1
) (
   input logic              clk,
   input logic              rst_n,
   input logic [N-1:0]      din,
   input logic              reg_wr,
   input logic [ADDR_W-1:0] reg_addr,
   input logic [N-1:0]      reg_wdata,
   input logic [N-1:0]      cause_q,
   input logic [N-1:0]      emask_q,
   input logic [N-1:0]      lmask_q,
   input logic [N-1:0]      edge_set,
   input logic [N/GW-1:0]   irq_grp
);
   localparam int NG = N / GW;

   logic          wr_c, wr_e, wr_l;
   logic [1:0]    cyc;
   logic [NG-1:0] exp_grp;

   assign wr_c = reg_wr && (reg_addr == ADDR_W'(CAUSE_OFS));
   assign wr_e = reg_wr && (reg_addr == ADDR_W'(EMASK_OFS + MASK_OFS));
   assign wr_l = reg_wr && (reg_addr == ADDR_W'(LMASK_OFS + MASK_OFS));

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)         cyc <= '0;
      else if (cyc != 3)  cyc <= cyc + 2'd1;
   end

   always_comb begin
      for (int g = 0; g < NG; g++) begin
         exp_grp[g] = 1'b0;
         for (int b = 0; b < GW; b++)
            exp_grp[g] = exp_grp[g] | (din[g*GW+b] & lmask_q[g*GW+b])
                                    | (cause_q[g*GW+b] & emask_q[g*GW+b]);
      end
   end

   assert_cause_hold_R2: assert property (@(posedge clk) disable iff (!rst_n)
      !wr_c |=> ((cause_q & $past(cause_q)) == $past(cause_q)));

   assert_edge_latch_R2: assert property (@(posedge clk) disable iff (!rst_n)
      (cyc == 2'd3) |-> ((($past(din) & ~$past(din, 2)) & ~cause_q) == '0));

   assert_w0c_R5: assert property (@(posedge clk) disable iff (!rst_n)
      wr_c |=> ((cause_q & ~$past(reg_wdata) & ~$past(edge_set)) == '0));

   assert_set_wins_R8: assert property (@(posedge clk) disable iff (!rst_n)
      1'b1 |=> ((($past(edge_set)) & ~cause_q) == '0));

   assert_lmask_wr_R3: assert property (@(posedge clk) disable iff (!rst_n)
      wr_l |=> (lmask_q == $past(reg_wdata)));

   assert_emask_wr_R4: assert property (@(posedge clk) disable iff (!rst_n)
      wr_e |=> (emask_q == $past(reg_wdata)));

   if (SUM_REG) begin : g_sum_reg
      assert_summary_R7: assert property (@(posedge clk) disable iff (!rst_n)
         (cyc != 2'd0) |-> (irq_grp == $past(exp_grp)));
   end else begin : g_sum_comb
      assert_summary_R6: assert property (@(posedge clk) disable iff (!rst_n)
         irq_grp == exp_grp);
   end
endmodule

bind gpio_irq_agg gpio_irq_chk #(
   .N(NUM_LINES), .GW(GROUP_W), .ADDR_W(ADDR_W), .MASK_OFS(MASK_OFS), .SUM_REG(SUM_REG)
) u_chk (
   .clk(clk), .rst_n(rst_n), .din(din), .reg_wr(reg_wr), .reg_addr(reg_addr),
   .reg_wdata(reg_wdata), .cause_q(cause_q), .emask_q(emask_q), .lmask_q(lmask_q),
   .edge_set(edge_set), .irq_grp(irq_grp)
);

// File: tb/sim_gpio_irq_agg.sv
module sim_gpio_irq_agg;
   localparam int N    = 32;
   localparam int GW   = 8;
   localparam int AW   = 8;
   localparam int MOFS = 32'h20;
   localparam int NG   = N / GW;
   localparam logic [AW-1:0] A_C = 8'h14;
   localparam logic [AW-1:0] A_E = 8'h18 + MOFS;
   localparam logic [AW-1:0] A_L = 8'h1C + MOFS;

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic [N-1:0]  din = '0;
   logic          reg_wr = 1'b0;
   logic [AW-1:0] reg_addr = '0;
   logic [N-1:0]  reg_wdata = '0;
   logic [N-1:0]  reg_rdata;
   logic [NG-1:0] irq_grp;

   int checks = 0;
   int fails  = 0;
   bit done   = 1'b0;

   always #10 clk = ~clk;

   gpio_irq_agg #(.NUM_LINES(N), .GROUP_W(GW), .ADDR_W(AW), .MASK_OFS(MOFS)) u0 (
      .clk(clk), .rst_n(rst_n), .din(din), .reg_wr(reg_wr), .reg_addr(reg_addr),
      .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .irq_grp(irq_grp)
   );

   task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
      checks++;
      if (act !== exp) begin
         fails++;
         $display("FAIL %s actual=%h expected=%h", req, act, exp);
      end
   endtask

   // one full cycle: leaves the bench just after the next falling edge
   task automatic step();
      @(posedge clk);
      @(negedge clk);
   endtask

   task automatic wr(input logic [AW-1:0] a, input logic [N-1:0] d);
      reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
      step();
      reg_wr = 1'b0;
   endtask

   task automatic rd(input logic [AW-1:0] a, output logic [N-1:0] d);
      reg_addr = a;
      #1 d = reg_rdata;
   endtask

   task automatic clear_all();
      din = '0;
      wr(A_L, '0);
      wr(A_E, '0);
      wr(A_C, '0);
      step();
   endtask

   task automatic t_reset();
      logic [N-1:0] v;
      rd(A_C, v); chk("R1 cause", v, 0);
      rd(A_E, v); chk("R1 emask", v, 0);
      rd(A_L, v); chk("R1 lmask", v, 0);
      chk("R1 irq", 32'(irq_grp), 0);
   endtask

   task automatic t_level();
      logic [N-1:0] v;
      wr(A_L, 32'h0000_0008);
      rd(A_L, v); chk("R3 lmask readback", v, 32'h8);
      din = 32'h0000_0208;          // line 3 masked in, line 9 masked out
      #1 chk("R7 not yet", 32'(irq_grp), 0);
      step();
      chk("R3 level irq", 32'(irq_grp), 32'h1);
      din = 32'h0000_0200;
      step();
      chk("R3 level follows input", 32'(irq_grp), 0);
      clear_all();
   endtask

   task automatic t_edge();
      logic [N-1:0] v;
      din[12] = 1'b1;
      step();
      rd(A_C, v); chk("R2 edge latched", v, 32'h0000_1000);
      din[12] = 1'b0;
      step();
      rd(A_C, v); chk("R2 held after fall", v, 32'h0000_1000);
      chk("R4 unmasked edge silent", 32'(irq_grp), 0);
      wr(A_E, 32'h0000_1000);
      rd(A_E, v); chk("R4 emask readback", v, 32'h1000);
      chk("R7 mask one cycle later", 32'(irq_grp), 0);
      step();
      chk("R4 edge irq", 32'(irq_grp), 32'h2);
      clear_all();
   endtask

   task automatic t_fall();
      logic [N-1:0] v;
      din = 32'h0000_0040;
      step();
      wr(A_C, '0);
      din = '0;
      step(); step();
      rd(A_C, v); chk("R2 falling sets nothing", v, 0);
      clear_all();
   endtask

   task automatic t_w0c();
      logic [N-1:0] v;
      din = 32'h0010_1000;
      step();
      din = '0;
      step();
      rd(A_C, v); chk("R2 two bits", v, 32'h0010_1000);
      wr(A_C, ~32'h0000_1000);
      rd(A_C, v); chk("R5 clear only zero bits", v, 32'h0010_0000);
      wr(A_C, 32'hFFFF_FFFF);
      rd(A_C, v); chk("R5 ones keep", v, 32'h0010_0000);
      clear_all();
   endtask

   task automatic t_set_wins();
      logic [N-1:0] v;
      din[20] = 1'b1;
      wr(A_C, '0);                  // clear and rising edge in same cycle
      rd(A_C, v); chk("R8 set wins", v, 32'h0010_0000);
      clear_all();
   endtask

   task automatic t_groups();
      wr(A_L, 32'hFFFF_FFFF);
      din = 32'h8000_0000;
      step();
      chk("R6 line31 group3", 32'(irq_grp), 32'h8);
      din = 32'h0000_0001;
      step();
      chk("R6 line0 group0", 32'(irq_grp), 32'h1);
      din = 32'h0001_0100;
      step();
      chk("R6 groups1and2", 32'(irq_grp), 32'h6);
      clear_all();
   endtask

   task automatic t_decode();
      logic [N-1:0] v;
      wr(A_L, 32'h1234_5678);
      rd(8'h1C, v); chk("R9 unrelocated lmask reads 0", v, 0);
      rd(8'h18, v); chk("R9 unrelocated emask reads 0", v, 0);
      rd(8'h00, v); chk("R9 unmapped reads 0", v, 0);
      rd(A_L, v); chk("R3 relocated lmask", v, 32'h1234_5678);
      clear_all();
   endtask

   initial begin
      #(20 * 100000);
      if (!done) begin
         fails++;
         $display("FAIL watchdog actual=hung expected=done");
         $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
         $finish;
      end
   end

   initial begin
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      step();
      t_reset();
      t_level();
      t_edge();
      t_fall();
      t_w0c();
      t_set_wins();
      t_groups();
      t_decode();
      done = 1'b1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
   end
endmodule